// File: doc/BRIEF.md
# Two-Wire Slave Block-Read Engine with CRC-8 Packet Error Code

This block is the slave side of an I2C-style two-wire bus. It serves block reads out of a byte memory that sits beside it. The read starts at a memory pointer that was loaded earlier through a pointer-load input. The master opens with a write-direction address and sends the block-read command byte. It then writes how many bytes it wants, issues a repeated START, readdresses the slave for reading, and clocks the bytes out.

When the packet error code enable is high, the slave appends one CRC-8 byte after the requested data. The CRC uses polynomial 0x07, starts at zero and is computed MSB first. It covers the write address byte, the command, the count, the read address byte and every data byte sent.

SCL and SDA come in as raw levels and pass through a synchronizer. The slave drives SDA only by pulling it low, through an output-enable. The memory side is a combinational read port: the block presents an address and receives the byte at that address.

Top module: `blkrd_slave`

## Requirements
- R1: After reset, sda_oe is 0 and mem_addr is 0.
- R2: The slave pulls SDA low in the acknowledge bit of an address byte {DEV_ADDR, 0} that follows a START. Any other first byte is left unacknowledged, and later bytes are also unacknowledged until the next START.
- R3: The command byte 0xA1 is acknowledged. Any other command byte is left unacknowledged, and the slave then ignores the bus until the next START.
- R4: The byte after the command is the count and is always acknowledged. After a repeated START, the address byte {DEV_ADDR, 1} is acknowledged.
- R5: Data bytes are sent MSB first from consecutive addresses starting at the pointer. The pointer, seen on mem_addr, advances by one for each data byte sent.
- R6: With pec_en high, the byte that follows the count-th data byte is the CRC-8 (polynomial 0x07, initial value 0x00, MSB first). The CRC covers the write address byte, the command, the count, the read address byte and all data bytes sent so far.
- R7: With pec_en low, no CRC byte is inserted, and the byte after the count-th data byte comes from the next memory address.
- R8: While the master keeps acknowledging (SDA low in the ninth bit), the slave keeps sending bytes from the following addresses, including after the CRC byte.
- R9: After the master leaves a byte unacknowledged, the slave releases SDA and drives nothing until the next START.
- R10: A START or STOP in the middle of a transfer aborts it. A following transaction is served in full, with its CRC computed only over the new bytes.
- R11: sda_oe changes only while SCL is low. Bits are taken from SDA on the rising edge of SCL.
- R12: A high ptr_load loads ptr_val into the pointer, and mem_addr shows the value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level from the bus |
| sda_i | input | 1 | SDA level from the bus |
| sda_o | output | 1 | SDA drive value, always 0 (open drain) |
| sda_oe | output | 1 | SDA pull-low enable |
| pec_en | input | 1 | Append the CRC-8 byte after the counted data |
| ptr_load | input | 1 | Load the memory pointer from ptr_val |
| ptr_val | input | AW | New pointer value |
| mem_addr | output | AW | Memory read address (current pointer) |
| mem_rdata | input | 8 | Memory byte at mem_addr |

## Verification
The bench builds the block with an 8-bit pointer, so pointer wraparound from 0xFF to 0x00 is reached within one short read. It uses a two-stage synchronizer and the CRC variant selected, so the PEC byte is checked against an independent serial CRC model. Its device address is 0x2D, which makes the write and read address bytes 0x5A and 0x5B. A zero count with PEC, which gives a CRC-only read, and continued reads past the PEC byte are both reachable with these values.

// File: rtl/blkrd_pkg.sv
package blkrd_pkg;

   localparam logic [7:0] BLOCK_READ_CMD = 8'hA1;
   localparam logic [7:0] CRC8_POLY      = 8'h07;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_ACKHOLD,
      ST_WAIT_RS,
      ST_TX,
      ST_TXEND,
      ST_MACK,
      ST_LOAD,
      ST_DONE
   } blk_state_e;

   typedef enum logic [1:0] {
      PH_ADDR_W,
      PH_CMD,
      PH_COUNT,
      PH_ADDR_R
   } rx_phase_e;

   function automatic logic [7:0] crc8_next(input logic [7:0] cur, input logic [7:0] data);
      logic [7:0] r;
      r = cur ^ data;
      for (int i = 0; i < 8; i++) begin
         r = r[7] ? ((r << 1) ^ CRC8_POLY) : (r << 1);
      end
      return r;
   endfunction

endpackage

// File: rtl/blkrd_line_sync.sv
module blkrd_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("blkrd_line_sync: STAGES must be 1 to 4");
   end

   if (STAGES == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b1;
         else        q <= din;
      end
      assign dout = q;
   end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], din};
      end
      assign dout = chain[STAGES-1];
   end

endmodule

// File: rtl/blkrd_bus_events.sv
module blkrd_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  = !scl_q && scl_s;
   assign scl_fall  = scl_q && !scl_s;
   assign start_det = scl_q && scl_s && sda_q && !sda_s;
   assign stop_det  = scl_q && scl_s && !sda_q && sda_s;

endmodule

// File: rtl/blkrd_pec_crc.sv
module blkrd_pec_crc (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       en,
   input  logic [7:0] din,
   output logic [7:0] crc
);
   import blkrd_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  crc <= 8'h00;
      else if (clr) crc <= 8'h00;
      else if (en)  crc <= crc8_next(crc, din);
   end

endmodule

// File: rtl/blkrd_slave.sv
module blkrd_slave #(
   parameter logic [6:0]  DEV_ADDR    = 7'h2D,
   parameter int unsigned AW          = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          PEC_SUPPORT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_o,
   output logic          sda_oe,
   input  logic          pec_en,
   input  logic          ptr_load,
   input  logic [AW-1:0] ptr_val,
   output logic [AW-1:0] mem_addr,
   input  logic [7:0]    mem_rdata
);
   import blkrd_pkg::*;

   localparam int unsigned IDX_W = 9;
   localparam logic [7:0]  ADDR_W_BYTE = {DEV_ADDR, 1'b0};
   localparam logic [7:0]  ADDR_R_BYTE = {DEV_ADDR, 1'b1};

   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("blkrd_slave: AW must be 1 to 16");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   blkrd_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_s));
   blkrd_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s));

   blkrd_bus_events u_events (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   blk_state_e       state;
   rx_phase_e        phase;
   logic [2:0]       bit_cnt;
   logic [7:0]       shreg;
   logic [7:0]       byte_cnt;
   logic [IDX_W-1:0] tx_idx;
   logic [AW-1:0]    ptr;

   logic [7:0] rx_byte;
   logic       rx_ok;
   logic       pec_slot;
   logic       load_fire;
   logic       crc_clr, crc_en;
   logic [7:0] crc_din, crc_val;
   logic [7:0] load_byte;

   assign rx_byte = {shreg[6:0], sda_s};

   always_comb begin
      unique case (phase)
         PH_ADDR_W: rx_ok = (rx_byte == ADDR_W_BYTE);
         PH_CMD:    rx_ok = (rx_byte == BLOCK_READ_CMD);
         PH_COUNT:  rx_ok = 1'b1;
         PH_ADDR_R: rx_ok = (rx_byte == ADDR_R_BYTE);
         default:   rx_ok = 1'b0;
      endcase
   end

   assign load_fire = scl_fall &&
                      (((state == ST_ACKHOLD) && (phase == PH_ADDR_R)) || (state == ST_LOAD));
   assign crc_clr   = start_det && (state != ST_WAIT_RS);
   assign crc_en    = ((state == ST_RX) && scl_rise && (bit_cnt == 3'd7) && rx_ok) ||
                      (load_fire && !pec_slot);
   assign crc_din   = (state == ST_RX) ? rx_byte : mem_rdata;

   if (PEC_SUPPORT) begin : g_pec
      blkrd_pec_crc u_crc (
         .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
         .din(crc_din), .crc(crc_val));
      assign pec_slot = pec_en && (tx_idx == {1'b0, byte_cnt});
   end else begin : g_no_pec
      assign crc_val  = 8'h00;
      assign pec_slot = 1'b0;
   end

   assign load_byte = pec_slot ? crc_val : mem_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      ptr <= '0;
      else if (ptr_load)               ptr <= ptr_val;
      else if (load_fire && !pec_slot) ptr <= ptr + 1'b1;
   end
   assign mem_addr = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase    <= PH_ADDR_W;
         bit_cnt  <= '0;
         shreg    <= '0;
         byte_cnt <= '0;
         tx_idx   <= '0;
         sda_oe   <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         sda_oe  <= 1'b0;
         bit_cnt <= '0;
         state   <= ST_RX;
         tx_idx  <= '0;
         phase   <= (state == ST_WAIT_RS) ? PH_ADDR_R : PH_ADDR_W;
      end else begin
         unique case (state)
            ST_RX: if (scl_rise) begin
               shreg   <= rx_byte;
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  state <= rx_ok ? ST_ACK : ST_IDLE;
                  if (phase == PH_COUNT) byte_cnt <= rx_byte;
               end
            end
            ST_ACK: if (scl_fall) begin
               sda_oe <= 1'b1;
               state  <= ST_ACKHOLD;
            end
            ST_ACKHOLD: if (scl_fall) begin
               sda_oe  <= 1'b0;
               bit_cnt <= '0;
               unique case (phase)
                  PH_ADDR_W: begin phase <= PH_CMD;   state <= ST_RX; end
                  PH_CMD:    begin phase <= PH_COUNT; state <= ST_RX; end
                  PH_COUNT:  state <= ST_WAIT_RS;
                  default:   state <= ST_TX;
               endcase
            end
            ST_TX: begin
               if (scl_rise) begin
                  bit_cnt <= bit_cnt + 3'd1;
                  if (bit_cnt == 3'd7) state <= ST_TXEND;
               end else if (scl_fall) begin
                  shreg  <= shreg << 1;
                  sda_oe <= !shreg[6];
               end
            end
            ST_TXEND: if (scl_fall) begin
               sda_oe <= 1'b0;
               state  <= ST_MACK;
            end
            ST_MACK: if (scl_rise) state <= sda_s ? ST_DONE : ST_LOAD;
            default: ;
         endcase
         if (load_fire) begin
            shreg   <= load_byte;
            sda_oe  <= !load_byte[7];
            bit_cnt <= '0;
            state   <= ST_TX;
            if (tx_idx != '1) tx_idx <= tx_idx + 1'b1;
         end
      end
   end

   assign sda_o = 1'b0;

endmodule

module blkrd_chk #(
   parameter int unsigned AW = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   scl_s,
   input logic                   sda_oe,
   input logic                   start_det,
   input logic                   stop_det,
   input blkrd_pkg::blk_state_e  state,
   input logic                   ptr_load,
   input logic [AW-1:0]          ptr_val,
   input logic [AW-1:0]          mem_addr
);
   import blkrd_pkg::*;

   // R11
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R10
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE) && !sda_oe);

   // R10
   start_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (state == ST_RX));

   // R12
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_load |=> (mem_addr == $past(ptr_val)));

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mem_addr) && !$past(ptr_load)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) || (state == ST_DONE)) |-> !sda_oe);

endmodule

bind blkrd_slave blkrd_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
   .start_det(start_det), .stop_det(stop_det), .state(state),
   .ptr_load(ptr_load), .ptr_val(ptr_val), .mem_addr(mem_addr));

// File: tb/test_blkrd_slave.sv
`timescale 1ns/1ps
module test_blkrd_slave;

   localparam logic [6:0] DEV   = 7'h2D;
   localparam logic [7:0] AWB   = {DEV, 1'b0};
   localparam logic [7:0] ARB   = {DEV, 1'b1};
   localparam int         Q     = 10;
   localparam int         NVEC  = 5;
   // {count[24:17], ptr[16:9], pec[8], extra[7:0]}
   localparam logic [24:0] VEC [NVEC] = '{
      {8'd3, 8'h10, 1'b1, 8'd0},
      {8'd1, 8'hFE, 1'b0, 8'd0},
      {8'd2, 8'hFF, 1'b1, 8'd2},
      {8'd0, 8'h40, 1'b1, 8'd0},
      {8'd4, 8'h80, 1'b0, 8'd1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       m_low = 1'b0;
   logic       pec_en = 1'b0;
   logic       ptr_load = 1'b0;
   logic [7:0] ptr_val = '0;
   logic [7:0] mem_addr;
   logic [7:0] mem_rdata;
   logic       sda_o, sda_oe;
   logic       sda_line;

   int n_tests = 0;
   int n_fail  = 0;
   int viol    = 0;
   logic oe_q  = 1'b0;
   bit done    = 1'b0;
   logic [7:0] crc;

   always #10 clk = !clk;

   function automatic logic [7:0] mem_f(input logic [7:0] a);
      return {a[2:0], a[7:3]} ^ 8'h5C;
   endfunction

   function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r = c;
      for (int i = 7; i >= 0; i--) begin
         logic fb = r[7] ^ d[i];
         r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
      return r;
   endfunction

   assign mem_rdata = mem_f(mem_addr);
   assign sda_line  = !(m_low || (sda_oe && !sda_o));

   blkrd_slave #(.DEV_ADDR(DEV), .AW(8), .SYNC_STAGES(2), .PEC_SUPPORT(1'b1)) i_blkrd_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_o(sda_o), .sda_oe(sda_oe), .pec_en(pec_en),
      .ptr_load(ptr_load), .ptr_val(ptr_val),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata));

   // R11 monitor: drive may only change while SCL is low
   always @(negedge clk) begin
      oe_q <= sda_oe;
      if (rst_n && scl_m && (sda_oe != oe_q)) viol++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic t_start();
      m_low = 1'b0; wq();
      scl_m = 1'b1; wq();
      m_low = 1'b1; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic t_stop();
      m_low = 1'b1; wq();
      scl_m = 1'b1; wq();
      m_low = 1'b0; wq();
   endtask

   task automatic wbit(input logic b);
      m_low = !b; wq();
      scl_m = 1'b1; wq(); wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic rbit(output logic b);
      m_low = 1'b0; wq();
      scl_m = 1'b1; wq();
      b = sda_line; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic wbyte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) wbit(d[i]);
      rbit(b);
      ack = !b;
   endtask

   task automatic rbyte(output logic [7:0] d, input logic give_ack);
      logic b;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         rbit(b);
         d = {d[6:0], b};
      end
      wbit(!give_ack);
   endtask

   task automatic load_ptr(input logic [7:0] p);
      @(negedge clk); ptr_val = p; ptr_load = 1'b1;
      @(negedge clk); ptr_load = 1'b0;
      chk(mem_addr == p, "R12 pointer load", mem_addr, p);
   endtask

   // front half: write addr, command, count, repeated start, read addr
   task automatic begin_read(input logic [7:0] cnt, input string tag);
      logic ack;
      crc = 8'h00;
      t_start();
      wbyte(AWB, ack); chk(ack, {tag, " R2 write address ACK"}, ack, 1);
      crc = crc_ref(crc, AWB);
      wbyte(8'hA1, ack); chk(ack, {tag, " R3 command ACK"}, ack, 1);
      crc = crc_ref(crc, 8'hA1);
      wbyte(cnt, ack); chk(ack, {tag, " R4 count ACK"}, ack, 1);
      crc = crc_ref(crc, cnt);
      t_start();
      wbyte(ARB, ack); chk(ack, {tag, " R4 read address ACK"}, ack, 1);
      crc = crc_ref(crc, ARB);
   endtask

   task automatic read_bytes(input logic [7:0] p, input logic [7:0] cnt, input bit pec,
                             input int extra, input string tag, output logic [7:0] a_end);
      logic [7:0] d, exp_b, a;
      int total;
      string req;
      total = int'(cnt) + (pec ? 1 : 0) + extra;
      a = p;
      for (int i = 0; i < total; i++) begin
         rbyte(d, i != total - 1);
         if (pec && i == int'(cnt)) begin
            exp_b = crc;
            req = "R6 PEC byte";
         end else begin
            exp_b = mem_f(a);
            if (i < int'(cnt)) begin
               crc = crc_ref(crc, exp_b);
               req = "R5 data byte";
            end else if (!pec && i == int'(cnt)) begin
               req = "R7 no PEC, next data";
            end else begin
               req = "R8 continued data";
            end
            a = a + 8'd1;
         end
         chk(d == exp_b, {tag, " ", req}, d, exp_b);
      end
      a_end = a;
   endtask

   initial begin
      logic ack;
      logic [7:0] d, a_end;
      repeat (5) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
      chk(mem_addr == 8'h00, "R1 mem_addr after reset", mem_addr, 0);

      // vector table
      for (int v = 0; v < NVEC; v++) begin
         load_ptr(VEC[v][16:9]);
         pec_en = VEC[v][8];
         begin_read(VEC[v][24:17], "vec");
         read_bytes(VEC[v][16:9], VEC[v][24:17], VEC[v][8], int'(VEC[v][7:0]), "vec", a_end);
         t_stop();
         chk(mem_addr == a_end, "R5 pointer after read", mem_addr, a_end);
      end

      // R2: foreign address, then later bytes ignored
      t_start();
      wbyte({7'h11, 1'b0}, ack); chk(!ack, "R2 foreign address NACK", ack, 0);
      wbyte(8'hA1, ack);         chk(!ack, "R2 ignored after NACK", ack, 0);
      t_stop();
      t_start();
      wbyte(ARB, ack);           chk(!ack, "R2 read bit in first byte NACK", ack, 0);
      t_stop();

      // R3: wrong command
      t_start();
      wbyte(AWB, ack);   chk(ack, "R3 address ACK", ack, 1);
      wbyte(8'hA0, ack); chk(!ack, "R3 wrong command NACK", ack, 0);
      wbyte(8'h02, ack); chk(!ack, "R3 idle after wrong command", ack, 0);
      t_stop();

      // R9: release after master NACK
      load_ptr(8'h30);
      pec_en = 1'b0;
      begin_read(8'd1, "nack");
      read_bytes(8'h30, 8'd1, 1'b0, 0, "nack", a_end);
      rbyte(d, 1'b0);
      chk(d == 8'hFF, "R9 bus released after NACK", d, 8'hFF);
      t_stop();

      // R10: START in the middle of the command byte
      load_ptr(8'h20);
      pec_en = 1'b1;
      t_start();
      wbyte(AWB, ack);
      wbit(1'b1); wbit(1'b0); wbit(1'b1);
      begin_read(8'd2, "R10 start abort");
      read_bytes(8'h20, 8'd2, 1'b1, 0, "R10 start abort", a_end);
      t_stop();

      // R10: STOP in the middle of the command byte
      load_ptr(8'h50);
      t_start();
      wbyte(AWB, ack);
      wbit(1'b1); wbit(1'b0);
      t_stop();
      begin_read(8'd1, "R10 stop abort");
      read_bytes(8'h50, 8'd1, 1'b1, 0, "R10 stop abort", a_end);
      t_stop();

      chk(viol == 0, "R11 sda_oe changed while SCL high", viol, 0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule